// File: doc/BRIEF.md
# Lamp Dimmer PWM Controller

This block turns a stream of single-cycle lamp commands into a slow pulse-width drive for a lamp. Four pulses control it: switch on, switch off, one step brighter, and one step dimmer. It keeps an on/off state and a brightness level between 1 and 31.

While the lamp is on, time is divided into ticks of `TICK_CYCLES` clocks each, which is about 78 µs with a 1 MHz clock. The output is high for as many ticks as the level. It is then low for the ticks that remain of a 32-tick frame. The frame length therefore never changes, and even full brightness keeps one low tick per frame. While the lamp is off, the output stays low.

The command decoder upstream supplies the pulses. The lamp output goes to a power switch.

Top module: `lamp_dimmer_pwm`

## Requirements
- R1: After reset the lamp is on and the level is 31. The output is high from reset, stays high for 31 ticks, then goes low for 1 tick.
- R2: While the lamp is on, each high phase lasts `level` ticks and each low phase lasts `32 - level` ticks. One tick is `TICK_CYCLES` clock cycles.
- R3: A brighter pulse raises the level by one. At 31 the level stays at 31.
- R4: A dimmer pulse lowers the level by one. At 1 the level stays at 1.
- R5: A brighter pulse and a dimmer pulse in the same cycle leave the level unchanged.
- R6: An off pulse drives the output low from the next clock edge. The output stays low until an on pulse arrives. Level pulses received while the lamp is off still change the level.
- R7: An on pulse drives the output high from the next clock edge and starts a fresh high phase of `level` ticks. The level used is the value held before that edge.
- R8: If on and off pulses arrive in the same cycle, the off pulse wins.
- R9: A level change does not shorten or lengthen the phase already running. The new level is used at the next phase reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_on | input | 1 | Switch-on pulse |
| cmd_off | input | 1 | Switch-off pulse |
| cmd_bright | input | 1 | One step brighter |
| cmd_dim | input | 1 | One step dimmer |
| lamp | output | 1 | Lamp drive level |

## Verification
Two events can land in the same cycle: a level command and the reload of the running phase. The bench provokes this by issuing a brighter pulse partway through a high phase while a monitor times every high and low run. The current run must keep its old length, and the next low and high runs must reflect the new level.

The bench also fires brighter and dimmer together, and on and off together. It judges those collisions by the frame timing that follows and by the output staying low.

// File: rtl/lamp_dimmer_pwm.sv
module lamp_dimmer_pwm #(
  parameter int TICK_CYCLES = 78,
  parameter int LVL_W       = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic cmd_bright,
  input  logic cmd_dim,
  output logic lamp
);
  localparam int LVL_MAX = (1 << LVL_W) - 1;
  localparam int TCW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [LVL_W:0]   FRAME  = (LVL_W+1)'(LVL_MAX + 1);
  localparam logic [LVL_W-1:0] TOP    = LVL_W'(LVL_MAX);
  localparam logic [LVL_W-1:0] ONE    = LVL_W'(1);
  localparam logic [TCW-1:0]   TLAST  = TCW'(TICK_CYCLES - 1);

  logic             lamp_on_q, phase_hi_q;
  logic [LVL_W-1:0] level_q, phase_q;
  logic [TCW-1:0]   tick_q;
  logic             tick, step_up, step_dn;
  logic [LVL_W:0]   off_wide;

  assign tick     = lamp_on_q && (tick_q == TLAST);
  assign step_up  = cmd_bright && !cmd_dim && (level_q != TOP);
  assign step_dn  = cmd_dim && !cmd_bright && (level_q != ONE);
  assign off_wide = FRAME - {1'b0, level_q};
  assign lamp     = lamp_on_q && phase_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= TOP;
    else if (step_up) level_q <= level_q + ONE;
    else if (step_dn) level_q <= level_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lamp_on_q  <= 1'b1;
      phase_hi_q <= 1'b1;
      phase_q    <= TOP;
      tick_q     <= '0;
    end else if (cmd_off) begin
      lamp_on_q <= 1'b0;
    end else if (cmd_on) begin
      lamp_on_q  <= 1'b1;
      phase_hi_q <= 1'b1;
      phase_q    <= level_q;
      tick_q     <= '0;
    end else if (lamp_on_q) begin
      if (tick) begin
        tick_q <= '0;
        if (phase_q == ONE) begin
          phase_hi_q <= !phase_hi_q;
          phase_q    <= phase_hi_q ? off_wide[LVL_W-1:0] : level_q;
        end else begin
          phase_q <= phase_q - ONE;
        end
      end else begin
        tick_q <= tick_q + TCW'(1);
      end
    end
  end
endmodule

// File: rtl/lamp_dimmer_pwm_chk.sv
module lamp_dimmer_pwm_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_on,
  input logic             cmd_off,
  input logic             cmd_bright,
  input logic             cmd_dim,
  input logic             lamp,
  input logic             tick,
  input logic [LVL_W-1:0] level_q
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'((1 << LVL_W) - 1);

  // R6
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> !lamp);

  // R7
  on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on && !cmd_off |=> lamp);

  // R5
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bright && cmd_dim |=> $stable(level_q));

  // R3
  bright_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bright && !cmd_dim && level_q != TOP |=> level_q == $past(level_q) + 1'b1);

  // R4
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q != '0);

  // R2
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cmd_on && !cmd_off |=> $stable(lamp));
endmodule

bind lamp_dimmer_pwm lamp_dimmer_pwm_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
  .cmd_bright(cmd_bright), .cmd_dim(cmd_dim), .lamp(lamp),
  .tick(tick), .level_q(level_q)
);

// File: tb/lamp_dimmer_pwm_tb.sv
module lamp_dimmer_pwm_tb_top;
  localparam int T = 3;
  logic clk = 0, rst_n = 0;
  logic cmd_on = 0, cmd_off = 0, cmd_bright = 0, cmd_dim = 0;
  logic lamp;
  int vectors = 0, miscompares = 0;

  lamp_dimmer_pwm #(.TICK_CYCLES(T), .LVL_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cmd_bright(cmd_bright), .cmd_dim(cmd_dim), .lamp(lamp));

  always #2 clk = ~clk;

  logic  exp_v[$];
  int    exp_n[$];
  string exp_r[$];
  bit mon_en = 0, mon_arm = 0;
  logic cur_v;
  int run_n;

  task automatic push(input logic v, input int ticks, input string r);
    exp_v.push_back(v); exp_n.push_back(ticks * T); exp_r.push_back(r);
  endtask

  always @(negedge clk) begin
    if (mon_arm) begin
      mon_arm = 0; mon_en = 1; cur_v = lamp; run_n = 1;
    end else if (mon_en) begin
      if (lamp === cur_v) run_n++;
      else begin
        vectors++;
        if (exp_n.size() == 0) begin
          miscompares++;
          $display("FAIL unexpected run: actual %0b x %0d, expected none", cur_v, run_n);
        end else begin
          logic ev; int en; string er;
          ev = exp_v.pop_front(); en = exp_n.pop_front(); er = exp_r.pop_front();
          if (ev !== cur_v || en != run_n) begin
            miscompares++;
            $display("FAIL %s run: actual %0b x %0d, expected %0b x %0d", er, cur_v, run_n, ev, en);
          end
        end
        cur_v = lamp; run_n = 1;
      end
    end
  end

  task automatic pulse(input logic on, input logic off, input logic br, input logic dm);
    @(posedge clk); #1;
    cmd_on = on; cmd_off = off; cmd_bright = br; cmd_dim = dm;
    @(posedge clk); #1;
    cmd_on = 0; cmd_off = 0; cmd_bright = 0; cmd_dim = 0;
  endtask

  task automatic arm();
    mon_arm = 1;
  endtask

  task automatic drain();
    while (exp_n.size() != 0) @(negedge clk);
    @(posedge clk); #1;
    mon_en = 0;
  endtask

  task automatic check_now(input logic exp, input string r);
    vectors++;
    if (lamp !== exp) begin
      miscompares++;
      $display("FAIL %s: lamp actual %0b, expected %0b", r, lamp, exp);
    end
  endtask

  task automatic hold_low(input int cycles, input string r);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (lamp !== 1'b0) bad++;
    end
    vectors++;
    if (bad != 0) begin
      miscompares++;
      $display("FAIL %s: lamp high in %0d cycles, expected 0", r, bad);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state, level 31
    check_now(1'b1, "R1");
    push(1, 31, "R1"); push(0, 1, "R1"); push(1, 31, "R1");
    arm(); drain();

    // R4: three dim steps to 28, R7 restart, R2 frame
    repeat (3) pulse(0, 0, 0, 1);
    pulse(1, 0, 0, 0);
    check_now(1'b1, "R7");
    push(1, 28, "R4"); push(0, 4, "R2"); push(1, 28, "R2");
    arm(); drain();

    // R5: bright and dim together leave 28
    pulse(0, 0, 1, 1);
    pulse(1, 0, 0, 0);
    push(1, 28, "R5"); push(0, 4, "R5");
    arm(); drain();

    // R3: five bright steps saturate at 31
    repeat (5) pulse(0, 0, 1, 0);
    pulse(1, 0, 0, 0);
    push(1, 31, "R3"); push(0, 1, "R3"); push(1, 31, "R3");
    arm(); drain();

    // R4: dim far below floor saturates at 1
    repeat (35) pulse(0, 0, 0, 1);
    pulse(1, 0, 0, 0);
    push(1, 1, "R4"); push(0, 31, "R4"); push(1, 1, "R4");
    arm(); drain();

    // R9: go to 10, then brighten mid high phase
    repeat (9) pulse(0, 0, 1, 0);
    pulse(1, 0, 0, 0);
    push(1, 10, "R9"); push(0, 21, "R9"); push(1, 11, "R9");
    arm();
    repeat (5) @(posedge clk);
    pulse(0, 0, 1, 0);
    drain();

    // R6: off forces low, level still moves while off (11 -> 13)
    pulse(0, 1, 0, 0);
    check_now(1'b0, "R6");
    pulse(0, 0, 1, 0);
    pulse(0, 0, 1, 0);
    hold_low(40 * T, "R6");
    pulse(1, 0, 0, 0);
    check_now(1'b1, "R7");
    push(1, 13, "R6"); push(0, 19, "R6"); push(1, 13, "R7");
    arm(); drain();

    // R8: on and off together, off wins
    pulse(1, 1, 0, 0);
    check_now(1'b0, "R8");
    hold_low(64 * T, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule